// File: doc/BRIEF.md
# Page Translator with Set-Associative Lookaside Cache

This block turns a 14-bit virtual byte address into a 12-bit physical byte address for a small byte-addressed system with 64-byte pages. The low six bits (the offset within the page) go through unchanged. The upper eight bits, the virtual page number, are looked up first in a 16-entry lookaside cache. That cache has four sets of four ways. When the lookup misses, the block reads a single-level mapping table held inside it, indexed by virtual page number. If the table entry is usable, the block copies it into the cache.

A requester presents one address at a time, together with a flag that marks the access as a write. A cache hit answers in the cycle after the request. A miss holds the block busy while it reads the table, and then ends with a completion pulse. Every access checks a read right and a write right, so every completion carries one of three results: a physical address, a missing-page fault, or a rights fault.

Software fills the mapping table through a simple write port. Each table write also removes any cached copy of that page. A separate flush input empties the whole cache in one cycle.

Top module: `page_translator`

## Requirements
- R1: After reset, `busy` and `done` are 0. Every cache entry and every table entry is invalid, so the first access to any page misses and ends with `pageFault`=1.
- R2: A successful access returns `paddr` = {physical page number, `reqVaddr[5:0]`}. The page offset is copied unchanged. The virtual page number is `reqVaddr[13:6]`.
- R3: The cache set is page-number bits 1:0 and the tag is page-number bits 7:2. An entry hits only when it is valid and its tag matches. A request accepted on a clock edge that hits shows `done`=1 and `tlbHit`=1 after that same edge.
- R4: A request accepted on a clock edge that misses keeps `busy`=1 and `done`=0 through the next two edges. After the second of those edges it shows `done`=1, `busy`=0 and `tlbHit`=0.
- R5: A table entry whose valid bit is 0 ends the access with `pageFault`=1, `protFault`=0 and `paddr`=0. Such an entry is not cached, so the next access to that page misses again.
- R6: Each mapping carries a read right and a write right. `reqWrite`=1 needs the write right and `reqWrite`=0 needs the read right. When the needed right is missing, the access ends with `protFault`=1 and `paddr`=0. This applies on a hit and on a miss.
- R7: A miss that finds a valid table entry installs that mapping in the cache, so the next access to the same page hits.
- R8: A refill goes to the lowest-numbered invalid way of the set. When all four ways are valid, it goes to the way named by that set's rotating pointer. The pointer starts at way 0 after reset and advances by one only on such a replacement.
- R9: While `busy`=1, `reqValid` is ignored. No extra completion occurs, and the ignored page is not cached.
- R10: A one-cycle `flush` invalidates every cache entry, so the next access to any page misses.
- R11: A table write to a page removes any cached copy of that page. The next access misses and returns the newly written mapping.
- R12: Each accepted request produces exactly one single-cycle `done` pulse, and `done` is 0 when no request has just finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request, accepted when not busy |
| reqVaddr | input | 14 | Virtual byte address |
| reqWrite | input | 1 | 1 = write access, 0 = read access |
| flush | input | 1 | Invalidate every cache entry |
| ptWrEn | input | 1 | Write one mapping-table entry |
| ptWrVpn | input | 8 | Page number of the entry being written |
| ptWrPpn | input | 6 | Physical page number to store |
| ptWrValid | input | 1 | Valid bit to store |
| ptWrRead | input | 1 | Read right to store |
| ptWrWrite | input | 1 | Write right to store |
| busy | output | 1 | A miss is in progress |
| done | output | 1 | One-cycle completion pulse |
| tlbHit | output | 1 | The finished access hit the cache |
| pageFault | output | 1 | The finished access found no valid mapping |
| protFault | output | 1 | The finished access lacked the needed right |
| paddr | output | 12 | Physical address, 0 on any fault |

## Verification
The bench builds the block with its default parameters: 14-bit virtual and 12-bit physical addresses, 64-byte pages, and four sets of four ways. The random phase draws page numbers only from 0 to 31, which gives eight pages per set against four ways. That makes full sets and rotating-pointer evictions frequent, and mixes them with table rewrites, flushes and denied rights. Directed cases cover the first access after reset, a fifth page forced into a full set, and a request held high through a whole miss.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  // Strobes from control to datapath, at most one active per cycle.
  typedef struct packed {
    logic finishHit;   // complete an accepted request from the cache
    logic latchReq;    // capture a request that missed
    logic readPte;     // read the mapping table for the captured page
    logic finishMiss;  // complete the miss, refill on a valid entry
  } xlStrobe_t;

  // Rights encoding: bit 1 = read allowed, bit 0 = write allowed
  typedef logic [1:0] perm_t;
endpackage

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      lookupHit,
  output xlStrobe_t strb,
  output logic      busy
);
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_RESOLVE} state_t;
  state_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strb      = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (lookupHit) strb.finishHit = 1'b1;
          else begin
            strb.latchReq = 1'b1;
            nextState     = ST_READ;
          end
        end
      end
      ST_READ: begin
        strb.readPte = 1'b1;
        nextState    = ST_RESOLVE;
      end
      ST_RESOLVE: begin
        strb.finishMiss = 1'b1;
        nextState       = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

  // A miss occupies exactly two busy cycles
  assert_miss_len_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |=> busy ##1 !busy);

  // No request is taken while a miss is outstanding
  assert_ignore_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(strb.finishHit || strb.latchReq));
endmodule

// File: rtl/xlate_dp.sv
module xlate_dp
  import xlate_pkg::*;
#(
  parameter int VA_W  = 14,
  parameter int PA_W  = 12,
  parameter int OFF_W = 6,
  parameter int SETS  = 4,
  parameter int WAYS  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  xlStrobe_t          strb,
  input  logic [VA_W-1:0]    reqVaddr,
  input  logic               reqWrite,
  input  logic               flush,
  input  logic               ptWrEn,
  input  logic [VA_W-OFF_W-1:0] ptWrVpn,
  input  logic [PA_W-OFF_W-1:0] ptWrPpn,
  input  logic               ptWrValid,
  input  logic               ptWrRead,
  input  logic               ptWrWrite,
  output logic               lookupHit,
  output logic               done,
  output logic               tlbHit,
  output logic               pageFault,
  output logic               protFault,
  output logic [PA_W-1:0]    paddr
);
  localparam int VPN_W    = VA_W - OFF_W;
  localparam int PPN_W    = PA_W - OFF_W;
  localparam int IDX_W    = $clog2(SETS);
  localparam int TAG_W    = VPN_W - IDX_W;
  localparam int WAY_W    = $clog2(WAYS);
  localparam int PT_DEPTH = 1 << VPN_W;

  // Cache storage
  logic [WAYS-1:0]  tlbVld  [SETS];
  logic [TAG_W-1:0] tlbTag  [SETS][WAYS];
  logic [PPN_W-1:0] tlbPpn  [SETS][WAYS];
  perm_t            tlbPerm [SETS][WAYS];
  logic [WAY_W-1:0] rrPtr   [SETS];

  // Mapping table storage
  logic [PT_DEPTH-1:0] ptVld;
  logic [PPN_W-1:0]    ptPpn  [PT_DEPTH];
  perm_t               ptPerm [PT_DEPTH];

  function automatic logic permOk(input perm_t p, input logic wr);
    return wr ? p[0] : p[1];
  endfunction

  // Lookup of the incoming address
  logic [VPN_W-1:0] inVpn;
  logic [IDX_W-1:0] inSet;
  logic [TAG_W-1:0] inTag;
  logic [WAYS-1:0]  hitVec;
  logic [PPN_W-1:0] hitPpn;
  perm_t            hitPerm;

  assign inVpn = reqVaddr[VA_W-1:OFF_W];
  assign inSet = inVpn[IDX_W-1:0];
  assign inTag = inVpn[VPN_W-1:IDX_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hitVec[w] = tlbVld[inSet][w] && (tlbTag[inSet][w] == inTag);
  end

  always_comb begin
    hitPpn  = '0;
    hitPerm = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hitVec[w]) begin
        hitPpn  = hitPpn  | tlbPpn[inSet][w];
        hitPerm = hitPerm | tlbPerm[inSet][w];
      end
    end
  end
  assign lookupHit = |hitVec;

  // Captured miss request and table read
  logic [VA_W-1:0]  latVaddr;
  logic             latWrite;
  logic             pteVld;
  logic [PPN_W-1:0] ptePpn;
  perm_t            ptePerm;
  logic [VPN_W-1:0] latVpn;
  logic [IDX_W-1:0] latSet;
  logic [TAG_W-1:0] latTag;

  assign latVpn = latVaddr[VA_W-1:OFF_W];
  assign latSet = latVpn[IDX_W-1:0];
  assign latTag = latVpn[VPN_W-1:IDX_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latVaddr <= '0;
      latWrite <= 1'b0;
      pteVld   <= 1'b0;
      ptePpn   <= '0;
      ptePerm  <= '0;
    end else begin
      if (strb.latchReq) begin
        latVaddr <= reqVaddr;
        latWrite <= reqWrite;
      end
      if (strb.readPte) begin
        pteVld  <= ptVld[latVpn];
        ptePpn  <= ptPpn[latVpn];
        ptePerm <= ptPerm[latVpn];
      end
    end
  end

  // Victim selection: lowest invalid way, else the rotating pointer
  logic [WAY_W-1:0] victim;
  logic             useRr;
  always_comb begin
    logic found;
    found  = 1'b0;
    victim = rrPtr[latSet];
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !tlbVld[latSet][w]) begin
        victim = WAY_W'(w);
        found  = 1'b1;
      end
    end
    useRr = !found;
  end

  // Write-port decode for invalidating a cached copy
  logic [IDX_W-1:0] wrSet;
  logic [TAG_W-1:0] wrTag;
  assign wrSet = ptWrVpn[IDX_W-1:0];
  assign wrTag = ptWrVpn[VPN_W-1:IDX_W];

  // Cache valid bits and pointers: refill, then invalidate, then flush
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        tlbVld[s] <= '0;
        rrPtr[s]  <= '0;
      end
    end else begin
      if (strb.finishMiss && pteVld) begin
        tlbVld[latSet][victim] <= 1'b1;
        if (useRr) rrPtr[latSet] <= rrPtr[latSet] + WAY_W'(1);
      end
      if (ptWrEn) begin
        for (int w = 0; w < WAYS; w++)
          if (tlbVld[wrSet][w] && (tlbTag[wrSet][w] == wrTag))
            tlbVld[wrSet][w] <= 1'b0;
      end
      if (flush) begin
        for (int s = 0; s < SETS; s++) tlbVld[s] <= '0;
      end
    end
  end

  // Cache payload needs no reset: guarded by valid bits
  always_ff @(posedge clk) begin
    if (strb.finishMiss && pteVld) begin
      tlbTag[latSet][victim]  <= latTag;
      tlbPpn[latSet][victim]  <= ptePpn;
      tlbPerm[latSet][victim] <= ptePerm;
    end
  end

  // Mapping table
  always_ff @(posedge clk) begin
    if (!rstN) ptVld <= '0;
    else if (ptWrEn) ptVld[ptWrVpn] <= ptWrValid;
  end

  always_ff @(posedge clk) begin
    if (ptWrEn) begin
      ptPpn[ptWrVpn]  <= ptWrPpn;
      ptPerm[ptWrVpn] <= {ptWrRead, ptWrWrite};
    end
  end

  // Result registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      done      <= 1'b0;
      tlbHit    <= 1'b0;
      pageFault <= 1'b0;
      protFault <= 1'b0;
      paddr     <= '0;
    end else begin
      done <= 1'b0;
      if (strb.finishHit) begin
        done      <= 1'b1;
        tlbHit    <= 1'b1;
        pageFault <= 1'b0;
        protFault <= !permOk(hitPerm, reqWrite);
        paddr     <= permOk(hitPerm, reqWrite) ?
                     {hitPpn, reqVaddr[OFF_W-1:0]} : '0;
      end else if (strb.finishMiss) begin
        done   <= 1'b1;
        tlbHit <= 1'b0;
        if (!pteVld) begin
          pageFault <= 1'b1;
          protFault <= 1'b0;
          paddr     <= '0;
        end else begin
          pageFault <= 1'b0;
          protFault <= !permOk(ptePerm, latWrite);
          paddr     <= permOk(ptePerm, latWrite) ?
                       {ptePpn, latVaddr[OFF_W-1:0]} : '0;
        end
      end
    end
  end

  logic anyVld;
  always_comb begin
    anyVld = 1'b0;
    for (int s = 0; s < SETS; s++) anyVld = anyVld | (|tlbVld[s]);
  end

  assert_hit_done_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.finishHit |=> (done && tlbHit && !pageFault));

  assert_miss_done_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.finishMiss |=> (done && !tlbHit));

  assert_fault_nopa_R5: assert property (@(posedge clk) disable iff (!rstN)
    (done && pageFault) |-> (paddr == '0 && !protFault && !tlbHit));

  assert_prot_nopa_R6: assert property (@(posedge clk) disable iff (!rstN)
    (done && protFault) |-> (paddr == '0));

  assert_unique_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  assert_flush_R10: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !anyVld);

  assert_done_src_R12: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(strb.finishHit || strb.finishMiss));
endmodule

// File: rtl/page_translator.sv
module page_translator
  import xlate_pkg::*;
#(
  parameter int VA_W  = 14,
  parameter int PA_W  = 12,
  parameter int OFF_W = 6,
  parameter int SETS  = 4,
  parameter int WAYS  = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [VA_W-1:0]       reqVaddr,
  input  logic                  reqWrite,
  input  logic                  flush,
  input  logic                  ptWrEn,
  input  logic [VA_W-OFF_W-1:0] ptWrVpn,
  input  logic [PA_W-OFF_W-1:0] ptWrPpn,
  input  logic                  ptWrValid,
  input  logic                  ptWrRead,
  input  logic                  ptWrWrite,
  output logic                  busy,
  output logic                  done,
  output logic                  tlbHit,
  output logic                  pageFault,
  output logic                  protFault,
  output logic [PA_W-1:0]       paddr
);
  xlStrobe_t strb;
  logic      lookupHit;

  xlate_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .lookupHit (lookupHit),
    .strb      (strb),
    .busy      (busy)
  );

  xlate_dp #(
    .VA_W (VA_W), .PA_W (PA_W), .OFF_W (OFF_W), .SETS (SETS), .WAYS (WAYS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqVaddr  (reqVaddr),
    .reqWrite  (reqWrite),
    .flush     (flush),
    .ptWrEn    (ptWrEn),
    .ptWrVpn   (ptWrVpn),
    .ptWrPpn   (ptWrPpn),
    .ptWrValid (ptWrValid),
    .ptWrRead  (ptWrRead),
    .ptWrWrite (ptWrWrite),
    .lookupHit (lookupHit),
    .done      (done),
    .tlbHit    (tlbHit),
    .pageFault (pageFault),
    .protFault (protFault),
    .paddr     (paddr)
  );
endmodule

// File: tb/sim_page_translator.sv
`timescale 1ns/1ps
module sim_page_translator;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [13:0] reqVaddr = '0;
  logic        reqWrite = 1'b0;
  logic        flush = 1'b0;
  logic        ptWrEn = 1'b0;
  logic [7:0]  ptWrVpn = '0;
  logic [5:0]  ptWrPpn = '0;
  logic        ptWrValid = 1'b0;
  logic        ptWrRead = 1'b0;
  logic        ptWrWrite = 1'b0;
  logic        busy, done, tlbHit, pageFault, protFault;
  logic [11:0] paddr;

  page_translator u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVaddr(reqVaddr),
    .reqWrite(reqWrite), .flush(flush), .ptWrEn(ptWrEn), .ptWrVpn(ptWrVpn),
    .ptWrPpn(ptWrPpn), .ptWrValid(ptWrValid), .ptWrRead(ptWrRead),
    .ptWrWrite(ptWrWrite), .busy(busy), .done(done), .tlbHit(tlbHit),
    .pageFault(pageFault), .protFault(protFault), .paddr(paddr)
  );

  always #10 clk = ~clk;  // 50 MHz

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;

  // Reference model state
  bit         mPtV [256];
  logic [5:0] mPtP [256];
  bit         mPtR [256];
  bit         mPtW [256];
  bit         mTv  [4][4];
  logic [5:0] mTtag[4][4];
  logic [5:0] mTppn[4][4];
  bit         mTr  [4][4];
  bit         mTw  [4][4];
  int         mRr  [4];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nFails++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic ptWrite(input logic [7:0] vpn, input logic [5:0] ppn,
                         input bit v, input bit r, input bit w);
    int s;
    @(negedge clk);
    ptWrEn = 1; ptWrVpn = vpn; ptWrPpn = ppn;
    ptWrValid = v; ptWrRead = r; ptWrWrite = w;
    @(negedge clk);
    ptWrEn = 0;
    mPtV[vpn] = v; mPtP[vpn] = ppn; mPtR[vpn] = r; mPtW[vpn] = w;
    s = int'(vpn[1:0]);
    for (int i = 0; i < 4; i++)
      if (mTv[s][i] && mTtag[s][i] == vpn[7:2]) mTv[s][i] = 0;
  endtask

  task automatic doFlush();
    @(negedge clk);
    flush = 1;
    @(negedge clk);
    flush = 0;
    for (int s = 0; s < 4; s++)
      for (int i = 0; i < 4; i++) mTv[s][i] = 0;
  endtask

  task automatic modelRefill(input logic [7:0] vpn);
    int s;
    int vic;
    s = int'(vpn[1:0]);
    vic = -1;
    for (int i = 0; i < 4; i++)
      if (vic < 0 && !mTv[s][i]) vic = i;
    if (vic < 0) begin
      vic = mRr[s];
      mRr[s] = (mRr[s] + 1) % 4;
    end
    mTv[s][vic] = 1; mTtag[s][vic] = vpn[7:2]; mTppn[s][vic] = mPtP[vpn];
    mTr[s][vic] = mPtR[vpn]; mTw[s][vic] = mPtW[vpn];
  endtask

  // Finish checks common to hits and misses once done is visible
  task automatic chkResult(input logic [13:0] va, input bit wr, input logic [5:0] ppn,
                           input bit r, input bit w);
    bit ok;
    logic [11:0] expPa;
    ok = wr ? w : r;
    expPa = {ppn, va[5:0]};
    chk(pageFault === 1'b0, "R5", "pageFault on mapped page", pageFault, 0);
    if (ok)
      chk(protFault === 1'b0 && paddr === expPa, "R2", "paddr", paddr, expPa);
    else
      chk(protFault === 1'b1 && paddr === 12'h0, "R6", "rights fault/paddr",
          {protFault, paddr}, 13'h1000);
  endtask

  task automatic doAccess(input logic [13:0] va, input bit wr);
    logic [7:0] vpn;
    int s;
    int hw;
    vpn = va[13:6];
    s = int'(vpn[1:0]);
    hw = -1;
    for (int i = 0; i < 4; i++)
      if (mTv[s][i] && mTtag[s][i] == vpn[7:2]) hw = i;
    @(negedge clk);
    reqValid = 1; reqVaddr = va; reqWrite = wr;
    @(negedge clk);
    reqValid = 0;
    if (hw >= 0) begin
      chk(done === 1'b1 && tlbHit === 1'b1 && busy === 1'b0, "R3", "hit done/tlbHit",
          {done, tlbHit, busy}, 3'b110);
      chkResult(va, wr, mTppn[s][hw], mTr[s][hw], mTw[s][hw]);
    end else begin
      chk(busy === 1'b1 && done === 1'b0, "R4", "miss cycle 1", {busy, done}, 2'b10);
      @(negedge clk);
      chk(busy === 1'b1 && done === 1'b0, "R4", "miss cycle 2", {busy, done}, 2'b10);
      @(negedge clk);
      chk(done === 1'b1 && busy === 1'b0 && tlbHit === 1'b0, "R4", "miss done",
          {done, busy, tlbHit}, 3'b100);
      if (!mPtV[vpn])
        chk(pageFault === 1'b1 && protFault === 1'b0 && paddr === 12'h0, "R5",
            "page fault", {pageFault, protFault, paddr}, 14'h2000);
      else begin
        chkResult(va, wr, mPtP[vpn], mPtR[vpn], mPtW[vpn]);
        modelRefill(vpn);
      end
    end
    @(negedge clk);
    chk(done === 1'b0, "R12", "done is one pulse", done, 0);
  endtask

  initial begin
    int unsigned seedv;
    seedv = $urandom(32'd2024);
    for (int i = 0; i < 256; i++) begin
      mPtV[i] = 0; mPtP[i] = '0; mPtR[i] = 0; mPtW[i] = 0;
    end
    for (int s = 0; s < 4; s++) begin
      mRr[s] = 0;
      for (int i = 0; i < 4; i++) mTv[s][i] = 0;
    end

    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R1", "idle after reset", {busy, done}, 0);

    // R1 / R5: untouched table, fault and no refill
    doAccess(14'h0000, 0);
    chk(pageFault === 1'b1, "R1", "first access faults", pageFault, 1);
    doAccess(14'h0012, 0);
    chk(tlbHit === 1'b0, "R5", "faulting page not cached", tlbHit, 0);

    // R2 / R7: map and translate
    ptWrite(8'h0F, 6'h0D, 1, 1, 1);
    doAccess(14'h03E9, 0);
    chk(paddr === 12'h369, "R2", "offset kept", paddr, 12'h369);
    doAccess(14'h03C1, 1);
    chk(tlbHit === 1'b1, "R7", "refilled page hits", tlbHit, 1);

    // R6: read-only and write-only pages, on miss and hit
    ptWrite(8'h03, 6'h02, 1, 1, 0);
    doAccess(14'h00C5, 1);
    chk(protFault === 1'b1, "R6", "write to read-only on miss", protFault, 1);
    doAccess(14'h00C6, 1);
    chk(protFault === 1'b1 && tlbHit === 1'b1, "R6", "write to read-only on hit",
        {protFault, tlbHit}, 2'b11);
    doAccess(14'h00C7, 0);
    ptWrite(8'h07, 6'h11, 1, 0, 1);
    doAccess(14'h01C0, 0);
    chk(protFault === 1'b1, "R6", "read of write-only", protFault, 1);
    doAccess(14'h01C3, 1);

    // R8: five pages in set 0
    ptWrite(8'h00, 6'h20, 1, 1, 1);
    ptWrite(8'h04, 6'h21, 1, 1, 1);
    ptWrite(8'h08, 6'h22, 1, 1, 1);
    ptWrite(8'h0C, 6'h23, 1, 1, 1);
    ptWrite(8'h10, 6'h24, 1, 1, 1);
    doAccess(14'h0000, 0);
    doAccess(14'h0100, 0);
    doAccess(14'h0200, 0);
    doAccess(14'h0300, 0);
    doAccess(14'h0400, 0);
    doAccess(14'h0100, 0);
    chk(tlbHit === 1'b1, "R8", "second fill survives first replacement", tlbHit, 1);
    doAccess(14'h0000, 0);
    chk(tlbHit === 1'b0, "R8", "first fill was replaced", tlbHit, 0);
    doAccess(14'h0100, 0);
    chk(tlbHit === 1'b0, "R8", "pointer advanced to way 1", tlbHit, 0);

    // R11: rewrite a cached page
    doAccess(14'h03C0, 0);
    ptWrite(8'h0F, 6'h21, 1, 1, 1);
    doAccess(14'h03C4, 0);
    chk(tlbHit === 1'b0 && paddr === 12'h844, "R11", "stale copy removed",
        {tlbHit, paddr}, 13'h0844);

    // R10: flush
    doAccess(14'h03C4, 0);
    doFlush();
    doAccess(14'h03C4, 0);
    chk(tlbHit === 1'b0, "R10", "miss after flush", tlbHit, 0);

    // R9: request held high through a miss
    ptWrite(8'h15, 6'h05, 1, 1, 1);
    ptWrite(8'h16, 6'h06, 1, 1, 1);
    @(negedge clk);
    reqValid = 1; reqVaddr = 14'h0547; reqWrite = 0;
    @(negedge clk);
    reqVaddr = 14'h0588;
    chk(busy === 1'b1 && done === 1'b0, "R9", "busy after accept", {busy, done}, 2'b10);
    @(negedge clk);
    chk(busy === 1'b1 && done === 1'b0, "R9", "held request ignored", {busy, done}, 2'b10);
    @(negedge clk);
    reqValid = 0;
    chk(done === 1'b1 && paddr === 12'h147, "R9", "first request result",
        {done, paddr}, 13'h1147);
    @(negedge clk);
    chk(done === 1'b0, "R9", "no extra completion", done, 0);
    modelRefill(8'h15);
    doAccess(14'h0588, 0);
    chk(tlbHit === 1'b0, "R9", "ignored page not cached", tlbHit, 0);

    // Random phase
    for (int n = 0; n < 400; n++) begin
      int op;
      op = int'($urandom_range(0, 19));
      if (op == 0) doFlush();
      else if (op <= 3)
        ptWrite(8'($urandom_range(0, 31)), 6'($urandom_range(0, 63)),
                $urandom_range(0, 4) != 0, 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)));
      else
        doAccess({8'($urandom_range(0, 31)), 6'($urandom_range(0, 63))},
                 1'($urandom_range(0, 1)));
    end

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule